// File: doc/BRIEF.md
# Indirect Memory Add-With-Carry Unit

This execution unit carries out one instruction family. The family adds a source register and the carry flag into a 4-bit data-memory nibble, and the nibble is addressed through a 16-bit index register. A 13-bit instruction word is presented with a `start` strobe. The unit decodes three things from it: which data register supplies the addend, which index register forms the address, and whether that index steps forward afterwards. The operation is a read-modify-write that always takes two cycles. In the first cycle the unit drives the address and a read strobe to a synchronous memory port. In the second cycle it writes the sum back, reports the new carry and zero flags and, when asked, reports the stepped index value.

The register file stays outside the unit. The unit samples the current A, B, X, Y and carry values on its inputs and returns write-enables and new values for the flags and the index. A separate prefix strobe can leave an 8-bit immediate pending. The next instruction of the non-stepping kind then takes its address from that immediate instead of the index: page 00xx when X is named and page FFxx when Y is named. The stepping kind disregards a pending prefix. Whatever instruction comes next, the prefix is consumed.

Top module: `adcm_unit`

## Requirements
- R1: An instruction is accepted when `start` is high in an idle cycle. It runs only if `instr[12:3]` equals 10'h33D (codes 19E8H to 19EFH). Bit 2 picks the addend (0 = A, 1 = B), bit 1 picks the index (0 = X, 1 = Y) and bit 0 requests a post-step. Any other code produces no memory access and no `done`.
- R2: In the cycle a valid instruction is accepted, `mem_re` is high and `mem_addr` carries the selected index value, unless R7 applies.
- R3: In the following cycle, `mem_we` and `done` are high for exactly one cycle at the same address. `mem_wdata` equals (M + r + C) mod 16, where M is the read nibble, r is the chosen register and C is `c_val` sampled at acceptance.
- R4: Alongside `done`, `flag_we` is high. `c_new` is the carry out of bit 3 of that sum, and `z_new` is 1 exactly when the written nibble is 0.
- R5: For a post-step code, `idx_we` is high with `done`, `idx_sel` names the index (0 = X, 1 = Y) and `idx_new` is the old index plus one, wrapping from FFFFH to 0000H. The flags still come only from the memory sum.
- R6: For a code with bit 0 clear, `idx_we` stays low.
- R7: After a one-cycle `ext_load` with `ext_imm` = k, the next accepted valid non-stepping instruction addresses {8'h00, k} for X or {8'hFF, k} for Y.
- R8: A post-step instruction that follows a prefix ignores it and addresses the index register.
- R9: Any accepted `start`, valid or not, clears a pending prefix, so the instruction after it uses the index again.
- R10: When `ext_load` and an accepted `start` coincide, the instruction uses the prefix state from before that cycle, and the new immediate stays pending for the next instruction.
- R11: A `start` seen during the second cycle of an instruction is ignored: there is no read in that cycle and only one `done`.
- R12: While reset is low, and in the first cycle after it, `mem_re`, `mem_we`, `done`, `flag_we` and `idx_we` are low, and no prefix is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Instruction issue strobe |
| instr | input | 13 | Instruction word |
| ext_load | input | 1 | Prefix strobe that makes `ext_imm` pending |
| ext_imm | input | 8 | Prefix immediate |
| a_val | input | 4 | Current A register |
| b_val | input | 4 | Current B register |
| x_val | input | 16 | Current X index |
| y_val | input | 16 | Current Y index |
| c_val | input | 1 | Current carry flag |
| mem_addr | output | 16 | Memory address (read in cycle 1, write in cycle 2) |
| mem_re | output | 1 | Read strobe; data returns next cycle |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | 4 | Write data |
| mem_rdata | input | 4 | Read data, one cycle after `mem_re` |
| done | output | 1 | High in the second cycle of an instruction |
| flag_we | output | 1 | Flag update enable |
| c_new | output | 1 | New carry flag |
| z_new | output | 1 | New zero flag |
| idx_we | output | 1 | Index update enable |
| idx_sel | output | 1 | Index being updated (0 = X, 1 = Y) |
| idx_new | output | 16 | Stepped index value |

## Verification
Two pairs of functions can fall in the same cycle here. A prefix load can arrive in the very cycle an instruction is accepted. A fresh `start` can arrive while the previous instruction is in its write cycle. The bench provokes the first by raising `ext_load` together with `start`. It then judges the read address of that instruction against the prefix state from before the cycle, and the address of the following instruction against the new immediate. It provokes the second by holding `start` across both cycles, and it requires no read strobe in the write cycle and exactly one scoreboard entry per accepted instruction.

// File: rtl/adcm_pkg.sv
package adcm_pkg;

    // Low opcode field positions; the decoder and the bench depend on them.
    localparam int unsigned LOW_W    = 3;
    localparam int unsigned BIT_SRC  = 2;
    localparam int unsigned BIT_IDX  = 1;
    localparam int unsigned BIT_STEP = 0;

    typedef enum logic {
        PH_IDLE  = 1'b0,
        PH_WRITE = 1'b1
    } adcm_phase_e;

    typedef struct packed {
        logic valid;
        logic src_b;
        logic idx_y;
        logic step;
    } adcm_op_t;

endpackage

// File: rtl/adcm_decode.sv
module adcm_decode
    import adcm_pkg::*;
#(
    parameter int unsigned OPC_W = 13,
    parameter logic [OPC_W-LOW_W-1:0] FAMILY = 10'h33D
) (
    input  logic [OPC_W-1:0] instr,
    output adcm_op_t         op
);
    localparam int unsigned HI_W = OPC_W - LOW_W;

    logic [HI_W-1:0] hi_field;

    always_comb begin
        hi_field = instr[OPC_W-1:LOW_W];
        op.valid = (hi_field == FAMILY);
        op.src_b = instr[BIT_SRC];
        op.idx_y = instr[BIT_IDX];
        op.step  = instr[BIT_STEP];
    end

endmodule

// File: rtl/adcm_agen.sv
module adcm_agen #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned IMM_W  = 8
) (
    input  logic              idx_y,
    input  logic              step,
    input  logic              ext_pend,
    input  logic [IMM_W-1:0]  ext_imm,
    input  logic [ADDR_W-1:0] x_val,
    input  logic [ADDR_W-1:0] y_val,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] idx_addr;
    logic [ADDR_W-1:0] page_addr;
    logic              use_page;

    generate
        if (IMM_W < ADDR_W) begin : g_paged
            localparam int unsigned PAGE_W = ADDR_W - IMM_W;
            always_comb begin
                page_addr = {{PAGE_W{idx_y}}, ext_imm};
            end
        end else begin : g_flat
            always_comb begin
                page_addr = ext_imm[ADDR_W-1:0];
            end
        end
    endgenerate

    always_comb begin
        idx_addr = idx_y ? y_val : x_val;
        use_page = ext_pend && !step;
        addr     = use_page ? page_addr : idx_addr;
    end

endmodule

// File: rtl/adcm_adder.sv
module adcm_adder #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         zero
);
    logic [W:0] chain;

    assign chain[0] = cin;

    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            logic prop;
            assign prop       = lhs[i] ^ rhs[i];
            assign sum[i]     = prop ^ chain[i];
            assign chain[i+1] = (lhs[i] & rhs[i]) | (prop & chain[i]);
        end
    endgenerate

    assign cout = chain[W];
    assign zero = (sum == '0);

endmodule

// File: rtl/adcm_unit.sv
module adcm_unit
    import adcm_pkg::*;
#(
    parameter int unsigned DATA_W = 4,
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned IMM_W  = 8,
    parameter int unsigned OPC_W  = 13,
    parameter logic [OPC_W-LOW_W-1:0] FAMILY = 10'h33D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [OPC_W-1:0]  instr,
    input  logic              ext_load,
    input  logic [IMM_W-1:0]  ext_imm,
    input  logic [DATA_W-1:0] a_val,
    input  logic [DATA_W-1:0] b_val,
    input  logic [ADDR_W-1:0] x_val,
    input  logic [ADDR_W-1:0] y_val,
    input  logic              c_val,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_re,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              done,
    output logic              flag_we,
    output logic              c_new,
    output logic              z_new,
    output logic              idx_we,
    output logic              idx_sel,
    output logic [ADDR_W-1:0] idx_new
);
    localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        adcm_phase_e       phase;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] opnd;
        logic              cin;
        logic              step;
        logic              idx_y;
        logic              ext_pend;
        logic [IMM_W-1:0]  ext_imm;
    } st_t;

    st_t st_d, st_q;

    adcm_op_t          op;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] sum;
    logic              sum_c;
    logic              sum_z;
    logic              accept;
    logic              go;
    logic              in_wr;

    adcm_decode #(
        .OPC_W  (OPC_W),
        .FAMILY (FAMILY)
    ) u_decode (
        .instr (instr),
        .op    (op)
    );

    adcm_agen #(
        .ADDR_W (ADDR_W),
        .IMM_W  (IMM_W)
    ) u_agen (
        .idx_y    (op.idx_y),
        .step     (op.step),
        .ext_pend (st_q.ext_pend),
        .ext_imm  (st_q.ext_imm),
        .x_val    (x_val),
        .y_val    (y_val),
        .addr     (rd_addr)
    );

    adcm_adder #(
        .W (DATA_W)
    ) u_adder (
        .lhs  (mem_rdata),
        .rhs  (st_q.opnd),
        .cin  (st_q.cin),
        .sum  (sum),
        .cout (sum_c),
        .zero (sum_z)
    );

    always_comb begin
        in_wr  = (st_q.phase == PH_WRITE);
        accept = start && !in_wr;
        go     = accept && op.valid;

        st_d = st_q;
        if (in_wr) begin
            st_d.phase = PH_IDLE;
        end
        if (accept) begin
            st_d.ext_pend = 1'b0;
        end
        if (go) begin
            st_d.phase = PH_WRITE;
            st_d.addr  = rd_addr;
            st_d.opnd  = op.src_b ? b_val : a_val;
            st_d.cin   = c_val;
            st_d.step  = op.step;
            st_d.idx_y = op.idx_y;
        end
        if (ext_load) begin
            st_d.ext_pend = 1'b1;
            st_d.ext_imm  = ext_imm;
        end

        mem_re    = go;
        mem_we    = in_wr;
        mem_addr  = in_wr ? st_q.addr : rd_addr;
        mem_wdata = sum;
        done      = in_wr;
        flag_we   = in_wr;
        c_new     = sum_c;
        z_new     = sum_z;
        idx_we    = in_wr && st_q.step;
        idx_sel   = st_q.idx_y;
        idx_new   = st_q.addr + ONE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n) mem_we |-> $past(mem_re)) else $error("write without read"); // R3
    AST_READ_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n) mem_re |=> done) else $error("read not followed by done"); // R3
    AST_WADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n) mem_we |-> (mem_addr == $past(mem_addr))) else $error("write address moved"); // R3
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done) else $error("done longer than one cycle"); // R3
    AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n) idx_we |-> (idx_new == ADDR_W'($past(mem_addr) + ONE))) else $error("index step wrong"); // R5
    AST_NO_READ_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n) mem_we |-> !mem_re) else $error("read during write cycle"); // R11

endmodule

// File: tb/sim_adcm_unit.sv
`timescale 1ns/1ps
module sim_adcm_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [12:0] instr = '0;
    logic        ext_load = 1'b0;
    logic [7:0]  ext_imm = '0;
    logic [3:0]  a_val = '0, b_val = '0;
    logic [15:0] x_val = '0, y_val = '0;
    logic        c_val = 1'b0;
    logic [15:0] mem_addr;
    logic        mem_re, mem_we;
    logic [3:0]  mem_wdata;
    logic [3:0]  mem_rdata;
    logic        done, flag_we, c_new, z_new, idx_we, idx_sel;
    logic [15:0] idx_new;

    int nchk = 0;
    int nerr = 0;

    always #10 clk = ~clk;

    adcm_unit u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
        .ext_load(ext_load), .ext_imm(ext_imm),
        .a_val(a_val), .b_val(b_val), .x_val(x_val), .y_val(y_val), .c_val(c_val),
        .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .done(done), .flag_we(flag_we), .c_new(c_new), .z_new(z_new),
        .idx_we(idx_we), .idx_sel(idx_sel), .idx_new(idx_new)
    );

    function automatic logic [9:0] slot(input logic [15:0] a);
        return {a[15], a[8:0]};
    endfunction

    function automatic logic [3:0] seed_val(input int i);
        return 4'((i * 7 + 3) & 15);
    endfunction

    // Memory model with a synchronous read port
    logic [3:0] mem [1024];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 1024; i++) mem[i] <= seed_val(i);
            mem_rdata <= '0;
        end else begin
            if (mem_we) mem[slot(mem_addr)] <= mem_wdata;
            if (mem_re) mem_rdata <= mem[slot(mem_addr)];
        end
    end

    // Reference state
    logic [3:0]  ref_mem [1024];
    logic [3:0]  ra, rb;
    logic [15:0] rx, ry;
    logic        cf;
    logic        ext_p;
    logic [7:0]  ext_v;

    typedef struct {
        logic [15:0] addr;
        logic [3:0]  wd;
        logic        c;
        logic        z;
        logic        iwe;
        logic        isel;
        logic [15:0] inew;
    } exp_t;
    exp_t sb[$];

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on every done
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb.size() == 0) begin
                chk("R11", "unexpected done", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk("R3", "write strobe", 32'(mem_we), 32'd1);
                chk("R3", "write address", 32'(mem_addr), 32'(e.addr));
                chk("R3", "write data", 32'(mem_wdata), 32'(e.wd));
                chk("R4", "flag enable", 32'(flag_we), 32'd1);
                chk("R4", "carry", 32'(c_new), 32'(e.c));
                chk("R4", "zero", 32'(z_new), 32'(e.z));
                chk(e.iwe ? "R5" : "R6", "index enable", 32'(idx_we), 32'(e.iwe));
                if (e.iwe) begin
                    chk("R5", "index select", 32'(idx_sel), 32'(e.isel));
                    chk("R5", "index value", 32'(idx_new), 32'(e.inew));
                end
            end
        end
    end

    task automatic prefix(input logic [7:0] imm);
        @(negedge clk);
        ext_load = 1'b1;
        ext_imm  = imm;
        @(negedge clk);
        ext_load = 1'b0;
        ext_p = 1'b1;
        ext_v = imm;
    endtask

    task automatic issue(input logic [12:0] code, input logic hold, input logic pf, input logic [7:0] pf_imm, input string req);
        logic        valid, srcb, iy, inc;
        logic [15:0] ea;
        logic [3:0]  r, m;
        logic [4:0]  s5;
        exp_t        e;
        @(negedge clk);
        a_val = ra; b_val = rb; x_val = rx; y_val = ry; c_val = cf;
        instr = code; start = 1'b1;
        ext_load = pf; ext_imm = pf_imm;
        valid = (code[12:3] == 10'h33D);
        srcb = code[2]; iy = code[1]; inc = code[0];
        ea = '0;
        if (valid) begin
            if (ext_p && !inc) ea = iy ? {8'hFF, ext_v} : {8'h00, ext_v};
            else ea = iy ? ry : rx;
            r  = srcb ? rb : ra;
            m  = ref_mem[slot(ea)];
            s5 = 5'(m) + 5'(r) + 5'(cf);
            e.addr = ea; e.wd = s5[3:0]; e.c = s5[4]; e.z = (s5[3:0] == 4'd0);
            e.iwe = inc; e.isel = iy; e.inew = ea + 16'd1;
            sb.push_back(e);
            ref_mem[slot(ea)] = s5[3:0];
            cf = s5[4];
            if (inc) begin
                if (iy) ry = ea + 16'd1;
                else    rx = ea + 16'd1;
            end
        end
        ext_p = pf;
        if (pf) ext_v = pf_imm;
        #1;
        chk(valid ? "R2" : "R1", "read strobe", 32'(mem_re), 32'(valid));
        if (valid) chk(req, "read address", 32'(mem_addr), 32'(ea));
        @(negedge clk);
        start = hold;
        ext_load = 1'b0;
        #1;
        if (hold) chk("R11", "read during write cycle", 32'(mem_re), 32'd0);
        if (!valid) chk("R1", "done for foreign code", 32'(done), 32'd0);
        @(negedge clk);
        start = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        logic [31:0] lcg;
        for (int i = 0; i < 1024; i++) ref_mem[i] = seed_val(i);
        ra = 4'd5; rb = 4'd9; rx = 16'h0123; ry = 16'h8042; cf = 1'b0;
        ext_p = 1'b0; ext_v = '0;
        repeat (3) @(negedge clk);
        #1;
        chk("R12", "read strobe in reset", 32'(mem_re), 32'd0);
        chk("R12", "write strobe in reset", 32'(mem_we), 32'd0);
        chk("R12", "done in reset", 32'(done), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk("R12", "flag enable after reset", 32'(flag_we), 32'd0);
        chk("R12", "index enable after reset", 32'(idx_we), 32'd0);

        // R12: no prefix pending after reset, so the index is used
        issue(13'h19E8, 1'b0, 1'b0, 8'h00, "R12");
        // R4: force carry and zero: M + B + 1 == 16
        cf = 1'b1;
        rb = 4'd15 - ref_mem[slot(ry)];
        issue(13'h19EE, 1'b0, 1'b0, 8'h00, "R4");
        // R5: post-step on X, then on Y at FFFF to show wrap
        issue(13'h19ED, 1'b0, 1'b0, 8'h00, "R5");
        ry = 16'hFFFF;
        issue(13'h19EB, 1'b0, 1'b0, 8'h00, "R5");
        chk("R5", "model wrap of Y", 32'(ry), 32'h0);
        // R7: prefix paging for X and Y
        prefix(8'h3C);
        issue(13'h19E8, 1'b0, 1'b0, 8'h00, "R7");
        prefix(8'h81);
        issue(13'h19EE, 1'b0, 1'b0, 8'h00, "R7");
        // R8 then R9: stepping form ignores the prefix, which is then gone
        prefix(8'h55);
        issue(13'h19E9, 1'b0, 1'b0, 8'h00, "R8");
        issue(13'h19EA, 1'b0, 1'b0, 8'h00, "R9");
        // R1 and R9: a foreign code consumes the prefix without touching memory
        prefix(8'h66);
        issue(13'h1A00, 1'b0, 1'b0, 8'h00, "R1");
        issue(13'h19EC, 1'b0, 1'b0, 8'h00, "R9");
        // R10: prefix load coinciding with an accepted instruction
        prefix(8'h10);
        issue(13'h19EA, 1'b0, 1'b1, 8'h22, "R10");
        issue(13'h19E8, 1'b0, 1'b0, 8'h00, "R10");
        // R11: start held into the write cycle
        issue(13'h19EC, 1'b1, 1'b0, 8'h00, "R11");
        @(negedge clk);

        // Mixed patterns across all eight codes
        lcg = 32'h1234_5678;
        for (int k = 0; k < 24; k++) begin
            lcg = lcg * 32'd1103515245 + 32'd12345;
            ra = lcg[19:16]; rb = lcg[23:20];
            rx = {lcg[31:24], lcg[15:8]}; ry = {lcg[15:8], lcg[31:24]};
            if (lcg[7]) prefix(lcg[15:8]);
            issue(13'h19E8 | 13'(k & 7), 1'b0, 1'b0, 8'h00, "R3");
        end

        repeat (3) @(negedge clk);
        chk("R3", "scoreboard drained", 32'(sb.size()), 32'd0);
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule